// File: doc/BRIEF.md
# Host Command Vector Interrupt Logic

This block lets an external host make the processor take an exception at a vector the host picks. The host writes one byte-wide command register. That register holds a vector field and a command bit, and both can be set in a single write. While the command bit is set, the processor sees a pending flag. An exception request goes to the exception controller only when the processor has enabled command interrupts and DMA mode is off. The vector address given with the request is twice the vector field.

The host can clear the command bit to withdraw the command at any time before the exception controller acknowledges it. On acknowledge the hardware clears the command bit. The host polls that bit to learn that the command was taken. The vector field is locked while a command is pending, so the address stays stable until the command is taken or withdrawn.

Top module: `host_cmd_vector`

## Requirements
- R1: After reset, the vector field is 0x12 and the command bit is 0. The register reads 0x12, the vector address is 0x24, and pending and request are low.
- R2: The register read value has the vector field in bits 4:0 and the command bit in bit 7. Bits 6:5 read 0. A host write with bit 7 set while the command bit is clear sets the command bit and loads bits 4:0 into the vector in the same write.
- R3: The vector address output is always twice the current vector field.
- R4: The pending output always equals the command bit.
- R5: The request is high exactly when the command bit is 1, the enable input is 1 and the DMA input is 0.
- R6: An acknowledge while the command bit is 1 clears the command bit, and so the pending flag, on the next clock edge.
- R7: A host write with bit 7 clear while a command is pending cancels it: the command bit clears and no request follows.
- R8: While the command bit is 1, host writes never change the vector field.
- R9: When a cancel write and an acknowledge arrive in the same cycle, the acknowledge takes priority and the write is ignored. The request and vector address stay valid in that cycle, and the command bit is 0 afterwards.
- R10: A host write with bit 7 clear while no command is pending loads the vector field and leaves the command bit at 0.
- R11: An acknowledge while the command bit is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the command register |
| host_wdata_i | input | 8 | Host write data: bit 7 is the command bit, bits 4:0 are the vector |
| cmd_rdata_o | output | 8 | Command register read value |
| cmd_ie_i | input | 1 | Command interrupt enable from the processor side |
| dma_on_i | input | 1 | DMA mode active; blocks the request |
| exc_ack_i | input | 1 | Acknowledge from the exception controller |
| pending_o | output | 1 | Command pending flag seen by the processor |
| exc_req_o | output | 1 | Exception request |
| vec_addr_o | output | 6 | Exception vector address (twice the vector field) |

## Verification
Several properties are checked by assertions on every cycle. The vector field holds while a command is pending. An acknowledge always clears the command bit. The command bit rises only on a host write with bit 7 set. The request never rises while DMA is on or the enable is low.

Other behaviours can only be shown by the bench scenarios. These are the exact read-back encoding and the address values for chosen vectors. They also include the cancel path and the same-cycle cancel-and-acknowledge case, where the address must be valid before the edge. The last is the case of an acknowledge arriving while idle.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CMD_BIT = 7;

  function automatic logic [5:0] vec_to_addr(input logic [4:0] v);
    return {v, 1'b0};
  endfunction
endpackage

// File: rtl/hcv_cmd_reg.sv
module hcv_cmd_reg
  import host_cmd_pkg::*;
#(
  parameter int unsigned HV_W = 5,
  parameter logic [HV_W-1:0] HV_RESET = 5'h12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ack_i,
  output logic [HV_W-1:0]  hv_o,
  output logic             hc_o
);
  logic [HV_W-1:0] hv_q;
  logic            hc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q <= HV_RESET;
      hc_q <= 1'b0;
    end else if (ack_i && hc_q) begin
      hc_q <= 1'b0;              // acknowledge beats any host write
    end else if (wr_en_i) begin
      hc_q <= wdata_i[CMD_BIT];
      if (!hc_q) hv_q <= wdata_i[HV_W-1:0];  // vector locked while pending
    end
  end

  assign hv_o = hv_q;
  assign hc_o = hc_q;

  AST_VEC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_q |=> $stable(hv_q)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && hc_q) |=> !hc_q); // R6
  AST_SET_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hc_q) |-> $past(wr_en_i && wdata_i[CMD_BIT] && !ack_i)); // R2
endmodule

// File: rtl/hcv_req_gen.sv
module hcv_req_gen #(
  parameter int unsigned HV_W = 5,
  localparam int unsigned ADDR_W = HV_W + 1
) (
  input  logic              hc_i,
  input  logic [HV_W-1:0]   hv_i,
  input  logic              ie_i,
  input  logic              dma_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    req_o  = hc_i && ie_i && !dma_i;
    addr_o = {hv_i, 1'b0};
  end
endmodule

// File: rtl/host_cmd_vector.sv
module host_cmd_vector
  import host_cmd_pkg::*;
#(
  parameter int unsigned HV_W = 5,
  parameter logic [HV_W-1:0] HV_RESET = 5'h12,
  localparam int unsigned ADDR_W = HV_W + 1,
  localparam int unsigned PAD_W  = CMD_BIT - HV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [REG_W-1:0]  host_wdata_i,
  output logic [REG_W-1:0]  cmd_rdata_o,
  input  logic              cmd_ie_i,
  input  logic              dma_on_i,
  input  logic              exc_ack_i,
  output logic              pending_o,
  output logic              exc_req_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic [HV_W-1:0] hv;
  logic            hc;

  hcv_cmd_reg #(.HV_W(HV_W), .HV_RESET(HV_RESET)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (host_wr_i),
    .wdata_i (host_wdata_i),
    .ack_i   (exc_ack_i),
    .hv_o    (hv),
    .hc_o    (hc)
  );

  hcv_req_gen #(.HV_W(HV_W)) u_req (
    .hc_i   (hc),
    .hv_i   (hv),
    .ie_i   (cmd_ie_i),
    .dma_i  (dma_on_i),
    .req_o  (exc_req_o),
    .addr_o (vec_addr_o)
  );

  assign pending_o   = hc;
  assign cmd_rdata_o = {hc, {PAD_W{1'b0}}, hv};

  AST_DMA_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_on_i |-> !exc_req_o); // R5
  AST_IE_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_ie_i |-> !exc_req_o); // R5
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_ack_i && !pending_o && !host_wr_i) |=> $stable(cmd_rdata_o)); // R11
endmodule

// File: tb/tb_host_cmd_vector.sv
`timescale 1ns/1ps
module tb_host_cmd_vector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ie = 1'b0;
  logic       dma = 1'b0;
  logic       ack = 1'b0;
  logic       pend;
  logic       req;
  logic [5:0] addr;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  host_cmd_vector dut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_wdata_i(wdata),
    .cmd_rdata_o(rdata), .cmd_ie_i(ie), .dma_on_i(dma), .exc_ack_i(ack),
    .pending_o(pend), .exc_req_o(req), .vec_addr_o(addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 8'h12);
    chk("R1 addr", addr, 6'h24);
    chk("R1 pending", pend, 0);
    chk("R1 req", req, 0);
  endtask

  task automatic t_set_and_gate();
    host_write(8'h85);
    chk("R2 rdata", rdata, 8'h85);
    chk("R3 addr", addr, 6'h0A);
    chk("R4 pending", pend, 1);
    chk("R5 req ie=0", req, 0);
    ie = 1'b1; #0.5;
    chk("R5 req ie=1", req, 1);
    dma = 1'b1; #0.5;
    chk("R5 req dma=1", req, 0);
    dma = 1'b0; #0.5;
  endtask

  task automatic t_ack();
    pulse_ack();
    chk("R6 rdata", rdata, 8'h05);
    chk("R6 pending", pend, 0);
    chk("R6 req", req, 0);
  endtask

  task automatic t_locked();
    host_write(8'h83);
    host_write(8'h9F);
    chk("R8 rdata", rdata, 8'h83);
    chk("R8 addr", addr, 6'h06);
  endtask

  task automatic t_cancel();
    host_write(8'h1E);
    chk("R7 rdata", rdata, 8'h03);
    chk("R7 req", req, 0);
  endtask

  task automatic t_cancel_ack();
    host_write(8'h8A);
    @(negedge clk); wr = 1'b1; wdata = 8'h00; ack = 1'b1; #0.5;
    chk("R9 req same cycle", req, 1);
    chk("R9 addr same cycle", addr, 6'h14);
    @(negedge clk); wr = 1'b0; ack = 1'b0;
    chk("R9 rdata after", rdata, 8'h0A);
    chk("R9 req after", req, 0);
  endtask

  task automatic t_idle_ack();
    pulse_ack();
    chk("R11 rdata", rdata, 8'h0A);
    chk("R11 pending", pend, 0);
  endtask

  task automatic t_write_clear();
    host_write(8'h1C);
    chk("R10 rdata", rdata, 8'h1C);
    chk("R10 addr", addr, 6'h38);
    chk("R10 pending", pend, 0);
    host_write(8'h9F);
    chk("R3 max addr", addr, 6'h3E);
    chk("R2 max rdata", rdata, 8'h9F);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_and_gate();
    t_ack();
    t_locked();
    t_cancel();
    t_cancel_ack();
    t_idle_ack();
    t_write_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule